// File: doc/BRIEF.md
# Command Stream Opcode Parser

This block sits at the front of a command processor. It takes a stream of 32-bit command words and sorts each accepted word into one of two kinds: a header that opens a command, or a payload word that belongs to the most recent header. A parser that starts out of reset treats its first word as a header. Each header is split into its fields and reported as one record. The payload words that follow are then counted off, and once the last one has been taken the next word is again a header.

The number of payload words depends on the opcode. For the two mask-carrying commands it is the number of ones in the mask, so headers and data fall at irregular places in the stream. Each payload word comes out with a strobe and the register offset it targets. That offset moves up by one per word for the incrementing write, stays put for the fixed-register write, and steps through the set mask bits from lowest to highest for the masked forms. Register writes, buffer fetches and waits are left to downstream logic.

Top module: `cmdp_parser`

## Requirements
- R1: A synchronous reset clears both strobes and drops `in_ready`, and the first word accepted afterwards is parsed as a header. This holds even when the reset arrives in the middle of a payload run. `in_ready` goes high on the first clock edge after reset is released.
- R2: For a header, `hdr_opcode` is taken from bits 31:28. Every record field that does not belong to that opcode reads zero.
- R3: Opcode 0 (set class) reports a class from bits 15:6, an offset from bits 27:16 and a 6-bit mask from bits 5:0. It is followed by as many payload words as the mask has ones, and a zero mask means none.
- R4: Opcodes 1 (incrementing write) and 2 (fixed write) report an offset from bits 27:16 and a payload length from bits 15:0. Under opcode 1 the payload offset starts at the header offset and grows by one per word, modulo 4096. Under opcode 2 every payload word carries the header offset.
- R5: Opcode 3 (masked write) reports an offset from bits 27:16 and a 16-bit mask from bits 15:0, with a payload length equal to the number of ones in the mask. For this opcode and for opcode 0, payload word k targets the header offset plus the position of the k-th set mask bit counted from bit 0, modulo 4096.
- R6: Opcode 4 (immediate) reports the offset from bits 27:16 and data from bits 15:0 on `hdr_imm`. Opcode 5 (restart) reports the word shifted left by four, kept to 32 bits, on `hdr_restart`. Neither has payload.
- R7: Opcode 6 (gather) reports the offset from bits 27:16, the insert flag from bit 15, the type flag from bit 14 and a 14-bit count from bits 13:0. It is followed by exactly one payload word, which carries the header offset.
- R8: Opcode 14 (extended) reads a sub-opcode from bits 27:24. Sub-opcode 0 raises `hdr_lock_acq` and sub-opcode 1 raises `hdr_lock_rel`, each with `hdr_lock` taken from bits 7:0. Any other sub-opcode raises only `hdr_ext_unknown`. There is no payload.
- R9: The opcodes 7 to 13 and 15 raise `hdr_illegal`, have no payload, and do not stall the stream.
- R10: The results for a word accepted at clock edge N are visible from edge N until edge N+1. `hdr_valid` and `pay_valid` are never high together, `hdr_plen` gives the payload word count, and `pay_last` marks the final payload word of a command.
- R11: A cycle with `in_valid` low produces no strobe and leaves the parse position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Parser can take a word |
| in_word | input | 32 | Command word |
| hdr_valid | output | 1 | Header record strobe |
| hdr_opcode | output | 4 | Opcode |
| hdr_class | output | 10 | Class (set class only) |
| hdr_offset | output | 12 | Register offset |
| hdr_mask | output | 16 | Mask (set class, masked write) |
| hdr_plen | output | 16 | Payload words following |
| hdr_imm | output | 16 | Immediate data |
| hdr_gcount | output | 14 | Gather count |
| hdr_insert | output | 1 | Gather insert flag |
| hdr_gtype | output | 1 | Gather type flag |
| hdr_lock | output | 8 | Lock index |
| hdr_lock_acq | output | 1 | Lock acquire |
| hdr_lock_rel | output | 1 | Lock release |
| hdr_ext_unknown | output | 1 | Unknown extended sub-opcode |
| hdr_illegal | output | 1 | Unlisted opcode |
| hdr_restart | output | 32 | Restart address |
| pay_valid | output | 1 | Payload word strobe |
| pay_data | output | 32 | Payload word |
| pay_offset | output | 12 | Target register offset |
| pay_last | output | 1 | Final payload word of command |

## Verification
Every result is due one clock edge after the word is accepted, because both the header record and the payload strobe come from a single register stage. The bench therefore offers a word, waits for the next rising edge, and samples two nanoseconds later. At that point it compares both strobes against a reference model kept in the bench, along with every header field or payload field the model expects to be live. Idle cycles are sampled at the same point, so a stray strobe or a lost parse position shows up on the very next word.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

  parameter int WORD_W  = 32;
  parameter int OP_W    = 4;
  parameter int OFFS_W  = 12;
  parameter int CLASS_W = 10;
  parameter int MASK_W  = 16;
  parameter int SMASK_W = 6;
  parameter int CNT_W   = 16;
  parameter int IMM_W   = 16;
  parameter int GCNT_W  = 14;
  parameter int LOCK_W  = 8;
  parameter int SUB_W   = 4;

  localparam int OP_LO      = WORD_W - OP_W;
  localparam int OFFS_LO    = 16;
  localparam int CLASS_LO   = 6;
  localparam int SUB_LO     = 24;
  localparam int INS_BIT    = 15;
  localparam int TYPE_BIT   = 14;
  localparam int RESTART_SH = 4;
  localparam int IDX_W      = $clog2(MASK_W);

  localparam logic [OP_W-1:0] OPC_SETCL   = 4'h0;
  localparam logic [OP_W-1:0] OPC_INCR    = 4'h1;
  localparam logic [OP_W-1:0] OPC_NONINCR = 4'h2;
  localparam logic [OP_W-1:0] OPC_MASK    = 4'h3;
  localparam logic [OP_W-1:0] OPC_IMM     = 4'h4;
  localparam logic [OP_W-1:0] OPC_RESTART = 4'h5;
  localparam logic [OP_W-1:0] OPC_GATHER  = 4'h6;
  localparam logic [OP_W-1:0] OPC_EXTEND  = 4'hE;

  localparam logic [SUB_W-1:0] SUB_ACQ = 4'h0;
  localparam logic [SUB_W-1:0] SUB_REL = 4'h1;

  typedef enum logic [1:0] {
    PM_FIXED = 2'd0,
    PM_INCR  = 2'd1,
    PM_MASK  = 2'd2
  } pmode_e;

  typedef struct packed {
    logic [OP_W-1:0]    opcode;
    logic [CLASS_W-1:0] cls;
    logic [OFFS_W-1:0]  offset;
    logic [MASK_W-1:0]  mask;
    logic [CNT_W-1:0]   plen;
    logic [IMM_W-1:0]   imm;
    logic [GCNT_W-1:0]  gcount;
    logic               insert;
    logic               gtype;
    logic [LOCK_W-1:0]  lock;
    logic               lock_acq;
    logic               lock_rel;
    logic               ext_unknown;
    logic               illegal;
    logic [WORD_W-1:0]  restart;
  } hdr_rec_t;

  // Number of ones in a mask, sized as a payload count.
  function automatic logic [CNT_W-1:0] ones_in(input logic [MASK_W-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < MASK_W; i++)
      c = c + {{(CNT_W-1){1'b0}}, m[i]};
    return c;
  endfunction

  // Position of the lowest set bit; zero for an empty mask.
  function automatic logic [IDX_W-1:0] lowest_set(input logic [MASK_W-1:0] m);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = MASK_W - 1; i >= 0; i--)
      if (m[i]) idx = IDX_W'(i);
    return idx;
  endfunction

  // Mask with its lowest set bit removed.
  function automatic logic [MASK_W-1:0] drop_lowest(input logic [MASK_W-1:0] m);
    return m & (m - MASK_W'(1));
  endfunction

endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
  import cmdp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_rec_t          rec,
  output pmode_e            pmode
);

  logic [OP_W-1:0]   op;
  logic [OFFS_W-1:0] offs;
  logic [SUB_W-1:0]  sub;
  logic [MASK_W-1:0] small_mask;
  logic [MASK_W-1:0] wide_mask;

  assign op         = word[OP_LO +: OP_W];
  assign offs       = word[OFFS_LO +: OFFS_W];
  assign sub        = word[SUB_LO +: SUB_W];
  assign small_mask = MASK_W'(word[SMASK_W-1:0]);
  assign wide_mask  = word[MASK_W-1:0];

  always_comb begin
    rec        = '0;
    pmode      = PM_FIXED;
    rec.opcode = op;
    case (op)
      OPC_SETCL: begin
        rec.cls    = word[CLASS_LO +: CLASS_W];
        rec.offset = offs;
        rec.mask   = small_mask;
        rec.plen   = ones_in(small_mask);
        pmode      = PM_MASK;
      end
      OPC_INCR: begin
        rec.offset = offs;
        rec.plen   = word[CNT_W-1:0];
        pmode      = PM_INCR;
      end
      OPC_NONINCR: begin
        rec.offset = offs;
        rec.plen   = word[CNT_W-1:0];
        pmode      = PM_FIXED;
      end
      OPC_MASK: begin
        rec.offset = offs;
        rec.mask   = wide_mask;
        rec.plen   = ones_in(wide_mask);
        pmode      = PM_MASK;
      end
      OPC_IMM: begin
        rec.offset = offs;
        rec.imm    = word[IMM_W-1:0];
      end
      OPC_RESTART: begin
        rec.restart = {word[WORD_W-RESTART_SH-1:0], {RESTART_SH{1'b0}}};
      end
      OPC_GATHER: begin
        rec.offset = offs;
        rec.insert = word[INS_BIT];
        rec.gtype  = word[TYPE_BIT];
        rec.gcount = word[GCNT_W-1:0];
        rec.plen   = CNT_W'(1);
        pmode      = PM_FIXED;
      end
      OPC_EXTEND: begin
        if (sub == SUB_ACQ) begin
          rec.lock_acq = 1'b1;
          rec.lock     = word[LOCK_W-1:0];
        end else if (sub == SUB_REL) begin
          rec.lock_rel = 1'b1;
          rec.lock     = word[LOCK_W-1:0];
        end else begin
          rec.ext_unknown = 1'b1;
        end
      end
      default: rec.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/cmdp_pay_track.sv
module cmdp_pay_track
  import cmdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_fire,
  input  logic              pay_fire,
  input  logic [CNT_W-1:0]  hdr_plen,
  input  pmode_e            hdr_pmode,
  input  logic [OFFS_W-1:0] hdr_offset,
  input  logic [MASK_W-1:0] hdr_mask,
  output logic              expect_hdr,
  output logic [OFFS_W-1:0] tgt_offset,
  output logic              last_word
);

  logic [CNT_W-1:0]  rem_q;
  pmode_e            mode_q;
  logic [OFFS_W-1:0] offs_q;
  logic [MASK_W-1:0] mask_q;

  assign expect_hdr = (rem_q == '0);
  assign last_word  = (rem_q == CNT_W'(1));
  assign tgt_offset = (mode_q == PM_MASK) ? offs_q + OFFS_W'(lowest_set(mask_q))
                                          : offs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      mode_q <= PM_FIXED;
      offs_q <= '0;
      mask_q <= '0;
    end else if (hdr_fire) begin
      rem_q  <= hdr_plen;
      mode_q <= hdr_pmode;
      offs_q <= hdr_offset;
      mask_q <= hdr_mask;
    end else if (pay_fire) begin
      rem_q <= rem_q - CNT_W'(1);
      case (mode_q)
        PM_INCR: offs_q <= offs_q + OFFS_W'(1);
        PM_MASK: mask_q <= drop_lowest(mask_q);
        default: ;
      endcase
    end
  end

  // R4: incrementing payload moves the target up by one
  p_incr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (pay_fire && mode_q == PM_INCR) |=> (offs_q == $past(offs_q) + OFFS_W'(1)));

  // R4: fixed payload keeps its target
  p_fixed_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pay_fire && mode_q == PM_FIXED) |=> $stable(offs_q));

  // R5: each masked payload word consumes exactly one mask bit
  p_mask_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (pay_fire && mode_q == PM_MASK) |=> ($countones(mask_q) + 1 == $countones($past(mask_q))));

  // R9: a zero-length header leaves the parser expecting a header
  p_zero_len_hdr_r9: assert property (@(posedge clk) disable iff (rst)
    (hdr_fire && hdr_plen == '0) |=> expect_hdr);

  // R10: the final payload word returns the parser to header state
  p_last_returns_r10: assert property (@(posedge clk) disable iff (rst)
    (pay_fire && last_word) |=> expect_hdr);

  // R11: no accepted word, no change of position
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!hdr_fire && !pay_fire) |=> $stable(rem_q));

endmodule

// File: rtl/cmdp_parser.sv
module cmdp_parser
  import cmdp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  output logic                hdr_valid,
  output logic [OP_W-1:0]     hdr_opcode,
  output logic [CLASS_W-1:0]  hdr_class,
  output logic [OFFS_W-1:0]   hdr_offset,
  output logic [MASK_W-1:0]   hdr_mask,
  output logic [CNT_W-1:0]    hdr_plen,
  output logic [IMM_W-1:0]    hdr_imm,
  output logic [GCNT_W-1:0]   hdr_gcount,
  output logic                hdr_insert,
  output logic                hdr_gtype,
  output logic [LOCK_W-1:0]   hdr_lock,
  output logic                hdr_lock_acq,
  output logic                hdr_lock_rel,
  output logic                hdr_ext_unknown,
  output logic                hdr_illegal,
  output logic [WORD_W-1:0]   hdr_restart,
  output logic                pay_valid,
  output logic [WORD_W-1:0]   pay_data,
  output logic [OFFS_W-1:0]   pay_offset,
  output logic                pay_last
);

  // Named internal events
  logic              ready_q;
  logic              accept;
  logic              expect_hdr;
  logic              hdr_fire;
  logic              pay_fire;
  hdr_rec_t          dec_rec;
  pmode_e            dec_pmode;
  logic [OFFS_W-1:0] tgt_offset;
  logic              last_word;

  hdr_rec_t          rec_q;
  logic              hdr_valid_q;
  logic              pay_valid_q;
  logic [WORD_W-1:0] pay_data_q;
  logic [OFFS_W-1:0] pay_offset_q;
  logic              pay_last_q;

  assign accept   = in_valid && ready_q;
  assign hdr_fire = accept && expect_hdr;
  assign pay_fire = accept && !expect_hdr;

  cmdp_hdr_decode u_dec (
    .word  (in_word),
    .rec   (dec_rec),
    .pmode (dec_pmode)
  );

  cmdp_pay_track u_trk (
    .clk        (clk),
    .rst        (rst),
    .hdr_fire   (hdr_fire),
    .pay_fire   (pay_fire),
    .hdr_plen   (dec_rec.plen),
    .hdr_pmode  (dec_pmode),
    .hdr_offset (dec_rec.offset),
    .hdr_mask   (dec_rec.mask),
    .expect_hdr (expect_hdr),
    .tgt_offset (tgt_offset),
    .last_word  (last_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q      <= 1'b0;
      hdr_valid_q  <= 1'b0;
      pay_valid_q  <= 1'b0;
      rec_q        <= '0;
      pay_data_q   <= '0;
      pay_offset_q <= '0;
      pay_last_q   <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      hdr_valid_q <= hdr_fire;
      pay_valid_q <= pay_fire;
      if (hdr_fire) rec_q <= dec_rec;
      if (pay_fire) begin
        pay_data_q   <= in_word;
        pay_offset_q <= tgt_offset;
        pay_last_q   <= last_word;
      end
    end
  end

  assign in_ready        = ready_q;
  assign hdr_valid       = hdr_valid_q;
  assign hdr_opcode      = rec_q.opcode;
  assign hdr_class       = rec_q.cls;
  assign hdr_offset      = rec_q.offset;
  assign hdr_mask        = rec_q.mask;
  assign hdr_plen        = rec_q.plen;
  assign hdr_imm         = rec_q.imm;
  assign hdr_gcount      = rec_q.gcount;
  assign hdr_insert      = rec_q.insert;
  assign hdr_gtype       = rec_q.gtype;
  assign hdr_lock        = rec_q.lock;
  assign hdr_lock_acq    = rec_q.lock_acq;
  assign hdr_lock_rel    = rec_q.lock_rel;
  assign hdr_ext_unknown = rec_q.ext_unknown;
  assign hdr_illegal     = rec_q.illegal;
  assign hdr_restart     = rec_q.restart;
  assign pay_valid       = pay_valid_q;
  assign pay_data        = pay_data_q;
  assign pay_offset      = pay_offset_q;
  assign pay_last        = pay_last_q;

  // R1: the cycle after reset shows no strobe and no readiness
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hdr_valid_q && !pay_valid_q && !ready_q));

  // R8: at most one extended or illegal flag per record
  p_flag_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    hdr_valid_q |-> $onehot0({rec_q.lock_acq, rec_q.lock_rel, rec_q.ext_unknown, rec_q.illegal}));

  // R7: a gather header is always followed by payload
  p_gather_pay_r7: assert property (@(posedge clk) disable iff (rst)
    (hdr_fire && in_word[OP_LO +: OP_W] == OPC_GATHER) |=> (!expect_hdr && last_word));

  // R10: header and payload strobes never coincide
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(hdr_valid_q && pay_valid_q));

  // R11: an idle cycle produces no strobe
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!hdr_valid_q && !pay_valid_q));

endmodule

// File: tb/cmdp_parser_test.sv
`timescale 1ns/1ps
module cmdp_parser_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, in_valid, in_ready;
  logic [31:0] in_word;
  logic        hdr_valid, hdr_insert, hdr_gtype, hdr_lock_acq, hdr_lock_rel;
  logic        hdr_ext_unknown, hdr_illegal, pay_valid, pay_last;
  logic [3:0]  hdr_opcode;
  logic [9:0]  hdr_class;
  logic [11:0] hdr_offset, pay_offset;
  logic [15:0] hdr_mask, hdr_plen, hdr_imm;
  logic [13:0] hdr_gcount;
  logic [7:0]  hdr_lock;
  logic [31:0] hdr_restart, pay_data;

  cmdp_parser uut (.*);

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench reference state
  int          m_rem = 0;
  int          m_kind = 0;   // 0 fixed, 1 step, 2 mask, 3 gather
  logic [11:0] m_offs = '0;
  logic [15:0] m_mask = '0;

  // expected outputs
  logic        e_hv, e_pv, e_ins, e_typ, e_acq, e_rel, e_unk, e_ill, e_last;
  logic [3:0]  e_op;
  logic [9:0]  e_cls;
  logic [11:0] e_offs, e_poffs;
  logic [15:0] e_mask, e_plen, e_imm;
  logic [13:0] e_gcnt;
  logic [7:0]  e_lock;
  logic [31:0] e_rst, e_pdata;

  function automatic int bits_set(input logic [15:0] v);
    int n = 0;
    for (int k = 0; k < 16; k++) if (v[k] == 1'b1) n++;
    return n;
  endfunction

  function automatic int first_one(input logic [15:0] v);
    for (int k = 0; k < 16; k++) if (v[k] == 1'b1) return k;
    return 0;
  endfunction

  task automatic compare(input string tag);
    logic [133:0] gh, eh;
    logic [44:0]  gp, ep;
    gh = {hdr_opcode, hdr_class, hdr_offset, hdr_mask, hdr_plen, hdr_imm, hdr_gcount,
          hdr_insert, hdr_gtype, hdr_lock, hdr_lock_acq, hdr_lock_rel, hdr_ext_unknown,
          hdr_illegal, hdr_restart};
    eh = {e_op, e_cls, e_offs, e_mask, e_plen, e_imm, e_gcnt, e_ins, e_typ, e_lock,
          e_acq, e_rel, e_unk, e_ill, e_rst};
    gp = {pay_data, pay_offset, pay_last};
    ep = {e_pdata, e_poffs, e_last};
    n_vec++;
    if (hdr_valid !== e_hv || pay_valid !== e_pv || (e_hv && gh !== eh) || (e_pv && gp !== ep)) begin
      n_bad++;
      $display("FAIL %s: got hv=%b pv=%b hdr=%h pay=%h, expected hv=%b pv=%b hdr=%h pay=%h",
               tag, hdr_valid, pay_valid, gh, gp, e_hv, e_pv, eh, ep);
    end
  endtask

  // Reference model: predicts the outputs for one accepted word.
  task automatic model_word(input logic [31:0] w, output string tag);
    e_hv = 0; e_pv = 0;
    {e_op, e_cls, e_offs, e_mask, e_plen, e_imm, e_gcnt, e_ins, e_typ, e_lock,
     e_acq, e_rel, e_unk, e_ill, e_rst} = '0;
    if (m_rem == 0) begin
      e_hv = 1;
      e_op = w[31:28];
      m_kind = 0;
      case (w[31:28])
        4'd0: begin
          e_cls = w[15:6]; e_offs = w[27:16]; e_mask = {10'd0, w[5:0]};
          e_plen = 16'(bits_set(e_mask)); m_kind = 2; tag = "R2 R3 set-class";
        end
        4'd1: begin e_offs = w[27:16]; e_plen = w[15:0]; m_kind = 1; tag = "R2 R4 incr"; end
        4'd2: begin e_offs = w[27:16]; e_plen = w[15:0]; tag = "R2 R4 fixed"; end
        4'd3: begin
          e_offs = w[27:16]; e_mask = w[15:0]; e_plen = 16'(bits_set(w[15:0]));
          m_kind = 2; tag = "R2 R5 masked";
        end
        4'd4: begin e_offs = w[27:16]; e_imm = w[15:0]; tag = "R2 R6 imm"; end
        4'd5: begin e_rst = w << 4; tag = "R2 R6 restart"; end
        4'd6: begin
          e_offs = w[27:16]; e_ins = w[15]; e_typ = w[14]; e_gcnt = w[13:0];
          e_plen = 16'd1; m_kind = 3; tag = "R2 R7 gather";
        end
        4'd14: begin
          tag = "R2 R8 extend";
          if (w[27:24] == 4'd0) begin e_acq = 1; e_lock = w[7:0]; end
          else if (w[27:24] == 4'd1) begin e_rel = 1; e_lock = w[7:0]; end
          else e_unk = 1;
        end
        default: begin e_ill = 1; tag = "R2 R9 illegal"; end
      endcase
      m_rem = int'(e_plen);
      m_offs = e_offs;
      m_mask = e_mask;
    end else begin
      e_pv = 1;
      e_pdata = w;
      e_last = (m_rem == 1);
      if (m_kind == 2) begin
        e_poffs = m_offs + 12'(first_one(m_mask));
        m_mask[first_one(m_mask)] = 1'b0;
        tag = "R5 R10 mask payload";
      end else begin
        e_poffs = m_offs;
        if (m_kind == 1) m_offs = m_offs + 12'd1;
        tag = (m_kind == 3) ? "R7 R10 gather payload" : "R4 R10 payload";
      end
      m_rem--;
    end
  endtask

  task automatic push(input logic [31:0] w);
    string tag;
    in_valid = 1'b1;
    in_word  = w;
    model_word(w, tag);
    @(posedge clk);
    #2;
    in_valid = 1'b0;
    compare(tag);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_word  = $urandom;
    e_hv = 0; e_pv = 0;
    @(posedge clk);
    #2;
    compare("R11 idle");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    n_vec++;
    if (hdr_valid !== 1'b0 || pay_valid !== 1'b0 || in_ready !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got hv=%b pv=%b rdy=%b, expected 0 0 0", hdr_valid, pay_valid, in_ready);
    end
    rst = 1'b0;
    m_rem = 0;
    @(posedge clk);
    #2;
    n_vec++;
    if (in_ready !== 1'b1 || hdr_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 ready: got rdy=%b hv=%b, expected 1 0", in_ready, hdr_valid);
    end
  endtask

  function automatic logic [31:0] rand_hdr();
    logic [31:0] w;
    logic [3:0]  op;
    w  = $urandom;
    op = 4'($urandom_range(0, 15));
    if (op == 4'd1 || op == 4'd2) w[15:0] = 16'($urandom_range(0, 6));
    if (op == 4'd14) w[27:24] = 4'($urandom_range(0, 3));
    w[31:28] = op;
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_word = '0;
    do_reset();

    // R4: zero-length incrementing write, next word is a header
    push(32'h1123_0000);
    push(32'h4456_BEEF);
    // R4: incrementing write wrapping at the top of the offset range
    push(32'h1FFF_0003);
    push(32'hAAAA_0001); push(32'hAAAA_0002); push(32'hAAAA_0003);
    // R4: fixed write with an idle gap in the payload (R11)
    push(32'h2010_0003);
    push(32'h1111_1111); idle(); push(32'h2222_2222); idle(); push(32'h3333_3333);
    // R5: masked write with wrap of base plus bit position
    push(32'h3FFE_8421);
    push(32'h0000_0001); push(32'h0000_0002); push(32'h0000_0003); push(32'h0000_0004);
    // R5: masked write with an empty mask
    push(32'h3123_0000);
    // R3: set class without and with a mask
    push(32'h0ABC_7FC0);
    push(32'h0100_00BF);
    for (int k = 0; k < 6; k++) push(32'hC0DE_0000 + k);
    // R6: immediate and restart with all ones
    push(32'h4FFF_FFFF);
    push(32'h5FFF_FFFF);
    // R7: gather with both flags
    push(32'h6321_FFFF);
    push(32'h8000_1000);
    // R8: extended acquire, release, unknown
    push(32'hE000_00A5);
    push(32'hE100_005A);
    push(32'hE5FF_FFFF);
    // R9: unlisted opcodes do not stall
    push(32'h7000_0003);
    push(32'hF123_4567);
    push(32'h4001_0002);

    // R1: reset in the middle of a payload run
    push(32'h1000_0005);
    push(32'h0000_0011); push(32'h0000_0022);
    do_reset();
    push(32'h4002_1234);

    // random mix
    for (int n = 0; n < 300; n++) begin
      push(rand_hdr());
      if ($urandom_range(0, 5) == 0) idle();
      while (m_rem > 0) begin
        if ($urandom_range(0, 4) == 0) idle();
        push($urandom);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule